// File: doc/BRIEF.md
# Burst-Capture Storage Sensor Sequencer

This block generates the digital timing for an image sensor that keeps its charge inside each pixel while a beam train is present and converts it only once the train is over. A single strobe starts a train. The sequencer then holds the photogate active and moves charge into the in-pixel storage register with a one-cycle transfer pulse at a fixed interval, for a set number of captures. At the default settings this gives 20 transfers 50 µs apart, which is 20 kHz across a 1 ms train.

When the last capture has been taken, the sequencer enters readout for the quiet gap. It selects one row at a time. For every stored sample in that row it issues four strobes in order: a reset pulse, a reference-sample strobe for the column converters, one storage-register shift, and a signal-sample strobe. Each strobe starts its own slot of a fixed length. At the defaults a sample takes 1 µs per slot.

After the last signal strobe of the last row, a one-cycle done pulse is issued and the block returns to idle. A start strobe that arrives during readout has no effect on the sequence, but it raises a sticky error flag. The row count, storage depth, capture count and both intervals are parameters. The intervals are counted in clock cycles.

Top module: `burst_store_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start strobe, every output is low: photoGate, xferPulse, rowSel, rstPulse, refStrobe, shiftPulse, sigStrobe, done and trainErr.
- R2: A start strobe seen in idle at clock edge E makes photoGate high for exactly CAPTURES*CAP_IVL cycles, beginning in the cycle after E.
- R3: Counting k=1 as the first cycle after E, xferPulse is high for one cycle at every k that is a multiple of CAP_IVL, up to and including k=CAPTURES*CAP_IVL. It is never high outside photoGate.
- R4: Readout begins at k=CAPTURES*CAP_IVL+1. No row is selected while photoGate is high.
- R5: Rows are selected one at a time with a one-hot rowSel, in ascending order starting at bit 0. Each row stays selected for DEPTH*4*RD_IVL consecutive cycles.
- R6: Each sample uses four consecutive slots of RD_IVL cycles. rstPulse is high in the first cycle of slot 0, refStrobe in the first cycle of slot 1, shiftPulse in the first cycle of slot 2, and sigStrobe in the first cycle of slot 3. Each of these strobes lasts one cycle.
- R7: At most one of xferPulse, rstPulse, refStrobe, shiftPulse and sigStrobe is high in any cycle.
- R8: done is high for exactly one cycle, at k=CAPTURES*CAP_IVL+ROWS*DEPTH*4*RD_IVL+1. After that every strobe, photoGate and rowSel stay low until the next start.
- R9: A start strobe during readout or in the done cycle does not alter any sequence output. trainErr goes high from the next cycle and stays high.
- R10: A start strobe during capture does not alter the sequence and leaves trainErr unchanged.
- R11: A start strobe accepted in idle clears trainErr from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trainStart | input | 1 | One-cycle strobe marking the start of a beam train |
| photoGate | output | 1 | Photogate active for the whole capture phase |
| xferPulse | output | 1 | Photogate-to-storage transfer pulse |
| rowSel | output | ROWS | One-hot row select during readout |
| rstPulse | output | 1 | Sense-node reset pulse |
| refStrobe | output | 1 | Reference-sample strobe to the column converters |
| shiftPulse | output | 1 | Storage-register shift clock |
| sigStrobe | output | 1 | Signal-sample strobe to the column converters |
| done | output | 1 | One-cycle pulse at the end of readout |
| trainErr | output | 1 | Sticky flag: a start strobe arrived during readout |

## Verification
The bench builds the block with ROWS=3, DEPTH=4, CAPTURES=4, CAP_IVL=8 and RD_IVL=4. With these values a whole train, including the change from one row to the next and the wrap of the sample counter, lasts only about 230 cycles. That is short enough to compare every output against a cycle-indexed model in every cycle. It also makes it cheap to drop stray start strobes at chosen points: mid-capture, mid-readout, on the very last readout cycle, and on the done cycle. The bench also applies a reset in the middle of a capture.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CAP,
    S_READ,
    S_DONE
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic clr;     // hold all counters at zero
    logic capRun;  // capture phase: interval timer paced by CAP_IVL
    logic rdRun;   // readout phase: interval timer paced by RD_IVL
  } seqCtl_t;

  // datapath -> control
  typedef struct packed {
    logic capLast; // final capture interval is ending this cycle
    logic rdLast;  // final readout slot is ending this cycle
  } seqSts_t;

endpackage

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    trainStart,
  input  seqSts_t sts,
  output seqCtl_t ctl,
  output logic    photoGate,
  output logic    done,
  output logic    trainErr
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: if (trainStart)  stateNxt = S_CAP;
      S_CAP:  if (sts.capLast) stateNxt = S_READ;
      S_READ: if (sts.rdLast)  stateNxt = S_DONE;
      S_DONE:                  stateNxt = S_IDLE;
      default:                 stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      trainErr <= 1'b0;
    end else begin
      state <= stateNxt;
      if (trainStart) begin
        if (state == S_IDLE)
          trainErr <= 1'b0;
        else if (state == S_READ || state == S_DONE)
          trainErr <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.clr    = (state == S_IDLE);
    ctl.capRun = (state == S_CAP);
    ctl.rdRun  = (state == S_READ);
  end

  assign photoGate = (state == S_CAP);
  assign done      = (state == S_DONE);

endmodule

// File: rtl/bss_dp.sv
module bss_dp
  import bss_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int DEPTH    = 20,
  parameter int CAPTURES = 20,
  parameter int CAP_IVL  = 10000,
  parameter int RD_IVL   = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seqCtl_t         ctl,
  output seqSts_t         sts,
  output logic            xferPulse,
  output logic [ROWS-1:0] rowSel,
  output logic            rstPulse,
  output logic            refStrobe,
  output logic            shiftPulse,
  output logic            sigStrobe
);

  localparam int MAXIVL = (CAP_IVL > RD_IVL) ? CAP_IVL : RD_IVL;
  localparam int TW = $clog2(MAXIVL + 1);
  localparam int CW = $clog2(CAPTURES + 1);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [TW-1:0] CAP_END  = TW'(CAP_IVL - 1);
  localparam logic [TW-1:0] RD_END   = TW'(RD_IVL - 1);
  localparam logic [CW-1:0] CAP_LAST = CW'(CAPTURES - 1);
  localparam logic [SW-1:0] SMP_LAST = SW'(DEPTH - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic [TW-1:0] timer;
  logic [CW-1:0] capCnt;
  logic [1:0]    phase;
  logic [SW-1:0] smp;
  logic [RW-1:0] row;
  logic          tmrEnd, tmrZero, slotWrap;

  assign tmrEnd = ctl.capRun ? (timer == CAP_END) : (timer == RD_END);
  assign tmrZero = (timer == '0);
  assign slotWrap = ctl.rdRun && tmrEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer  <= '0;
      capCnt <= '0;
      phase  <= '0;
      smp    <= '0;
      row    <= '0;
    end else if (ctl.clr) begin
      timer  <= '0;
      capCnt <= '0;
      phase  <= '0;
      smp    <= '0;
      row    <= '0;
    end else begin
      if (ctl.capRun || ctl.rdRun)
        timer <= tmrEnd ? '0 : timer + 1'b1;
      if (ctl.capRun && tmrEnd)
        capCnt <= capCnt + 1'b1;
      if (slotWrap) begin
        phase <= phase + 1'b1;
        if (phase == 2'd3) begin
          if (smp == SMP_LAST) begin
            smp <= '0;
            row <= row + 1'b1;
          end else begin
            smp <= smp + 1'b1;
          end
        end
      end
    end
  end

  assign sts.capLast = ctl.capRun && tmrEnd && (capCnt == CAP_LAST);
  assign sts.rdLast  = slotWrap && (phase == 2'd3) && (smp == SMP_LAST) && (row == ROW_LAST);

  assign xferPulse  = ctl.capRun && tmrEnd;
  assign rstPulse   = ctl.rdRun && tmrZero && (phase == 2'd0);
  assign refStrobe  = ctl.rdRun && tmrZero && (phase == 2'd1);
  assign shiftPulse = ctl.rdRun && tmrZero && (phase == 2'd2);
  assign sigStrobe  = ctl.rdRun && tmrZero && (phase == 2'd3);

  for (genvar g = 0; g < ROWS; g++) begin : g_rowDec
    assign rowSel[g] = ctl.rdRun && (row == RW'(g));
  end

endmodule

// File: rtl/burst_store_seq.sv
module burst_store_seq #(
  parameter int ROWS     = 16,
  parameter int DEPTH    = 20,
  parameter int CAPTURES = 20,
  parameter int CAP_IVL  = 10000,
  parameter int RD_IVL   = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trainStart,
  output logic            photoGate,
  output logic            xferPulse,
  output logic [ROWS-1:0] rowSel,
  output logic            rstPulse,
  output logic            refStrobe,
  output logic            shiftPulse,
  output logic            sigStrobe,
  output logic            done,
  output logic            trainErr
);

  bss_pkg::seqCtl_t ctl;
  bss_pkg::seqSts_t sts;

  bss_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trainStart (trainStart),
    .sts        (sts),
    .ctl        (ctl),
    .photoGate  (photoGate),
    .done       (done),
    .trainErr   (trainErr)
  );

  bss_dp #(
    .ROWS     (ROWS),
    .DEPTH    (DEPTH),
    .CAPTURES (CAPTURES),
    .CAP_IVL  (CAP_IVL),
    .RD_IVL   (RD_IVL)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .sts        (sts),
    .xferPulse  (xferPulse),
    .rowSel     (rowSel),
    .rstPulse   (rstPulse),
    .refStrobe  (refStrobe),
    .shiftPulse (shiftPulse),
    .sigStrobe  (sigStrobe)
  );

endmodule

// File: rtl/bss_chk.sv
module bss_chk #(
  parameter int ROWS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trainStart,
  input logic            photoGate,
  input logic            xferPulse,
  input logic [ROWS-1:0] rowSel,
  input logic            rstPulse,
  input logic            refStrobe,
  input logic            shiftPulse,
  input logic            sigStrobe,
  input logic            done,
  input logic            trainErr
);

  a_r3_xfer_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    xferPulse |-> photoGate);

  a_r4_gate_excl_row: assert property (@(posedge clk) disable iff (!rst_n)
    !(photoGate && (rowSel != '0)));

  a_r5_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowSel));

  a_r6_strobe_has_row: assert property (@(posedge clk) disable iff (!rst_n)
    (rstPulse || refStrobe || shiftPulse || sigStrobe) |-> (rowSel != '0));

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xferPulse, rstPulse, refStrobe, shiftPulse, sigStrobe}) <= 1);

  a_r8_done_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !photoGate && (rowSel == '0)));

  a_r9_err_on_read_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trainStart && ((rowSel != '0) || done)) |=> trainErr);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trainErr && !trainStart) |=> trainErr);

endmodule

bind burst_store_seq bss_chk #(.ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trainStart (trainStart),
  .photoGate  (photoGate),
  .xferPulse  (xferPulse),
  .rowSel     (rowSel),
  .rstPulse   (rstPulse),
  .refStrobe  (refStrobe),
  .shiftPulse (shiftPulse),
  .sigStrobe  (sigStrobe),
  .done       (done),
  .trainErr   (trainErr)
);

// File: tb/burst_store_seq_tb.sv
module burst_store_seq_tb;

  localparam int ROWS = 3;
  localparam int DEPTH = 4;
  localparam int CAPTURES = 4;
  localparam int CAP_IVL = 8;
  localparam int RD_IVL = 4;
  localparam int KC = CAPTURES * CAP_IVL;
  localparam int RL = ROWS * DEPTH * 4 * RD_IVL;
  localparam int KD = KC + RL + 1;
  localparam int NV = 5;
  // stray-start cycle for each run (-1 none): capture, readout, last read cycle, done cycle
  localparam int INJ [NV] = '{-1, 5, 40, KC + RL, KD};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trainStart = 1'b0;
  logic photoGate, xferPulse, rstPulse, refStrobe, shiftPulse, sigStrobe, done, trainErr;
  logic [ROWS-1:0] rowSel;
  int nChk = 0;
  int nBad = 0;
  logic expErr = 1'b0;

  always #2.5 clk = ~clk;

  burst_store_seq #(
    .ROWS(ROWS), .DEPTH(DEPTH), .CAPTURES(CAPTURES), .CAP_IVL(CAP_IVL), .RD_IVL(RD_IVL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .trainStart(trainStart), .photoGate(photoGate),
    .xferPulse(xferPulse), .rowSel(rowSel), .rstPulse(rstPulse), .refStrobe(refStrobe),
    .shiftPulse(shiftPulse), .sigStrobe(sigStrobe), .done(done), .trainErr(trainErr)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(string req);
    cmp(req, "photoGate", 32'(photoGate), 0);
    cmp(req, "strobes", 32'({xferPulse, rstPulse, refStrobe, shiftPulse, sigStrobe}), 0);
    cmp(req, "rowSel", 32'(rowSel), 0);
    cmp(req, "done", 32'(done), 0);
  endtask

  // model of cycle k after the accepted start edge
  task automatic checkCycle(int k);
    logic eGate, eXfer, eRst, eRef, eSh, eSig, eDone;
    logic [ROWS-1:0] eRow;
    eGate = (k >= 1 && k <= KC);
    eXfer = eGate && (k % CAP_IVL == 0);
    eRow = '0; eRst = 0; eRef = 0; eSh = 0; eSig = 0;
    if (k > KC && k <= KC + RL) begin
      int j, ph;
      logic first;
      j = k - KC - 1;
      ph = (j / RD_IVL) % 4;
      first = (j % RD_IVL == 0);
      eRow = ROWS'(1) << ((j / (4 * RD_IVL)) / DEPTH);
      eRst = first && ph == 0;
      eRef = first && ph == 1;
      eSh  = first && ph == 2;
      eSig = first && ph == 3;
    end
    eDone = (k == KD);
    cmp("R2", $sformatf("photoGate k=%0d", k), 32'(photoGate), 32'(eGate));
    cmp("R3", $sformatf("xferPulse k=%0d", k), 32'(xferPulse), 32'(eXfer));
    cmp("R5", $sformatf("rowSel k=%0d", k), 32'(rowSel), 32'(eRow));
    cmp("R6", $sformatf("rst/ref/shift/sig k=%0d", k),
        32'({rstPulse, refStrobe, shiftPulse, sigStrobe}), 32'({eRst, eRef, eSh, eSig}));
    cmp("R8", $sformatf("done k=%0d", k), 32'(done), 32'(eDone));
    cmp("R9", $sformatf("trainErr k=%0d", k), 32'(trainErr), 32'(expErr));
  endtask

  task automatic runTrain(int inj);
    @(negedge clk);
    trainStart = 1'b1;
    @(negedge clk);
    trainStart = 1'b0;
    expErr = 1'b0;
    cmp("R11", "trainErr cleared on accept", 32'(trainErr), 0);
    for (int k = 1; k <= KD + 3; k++) begin
      if (k > 1) @(negedge clk);
      trainStart = 1'b0;
      checkCycle(k);
      if (k == inj) begin
        trainStart = 1'b1;
        // R9 / R10: only readout and done set the flag
        expErr = (inj > KC) ? 1'b1 : expErr;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1");
    cmp("R1", "trainErr in reset", 32'(trainErr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");

    for (int v = 0; v < NV; v++) runTrain(INJ[v]);
    // after the done-cycle stray, flag must still be high in idle
    cmp("R9", "trainErr held in idle", 32'(trainErr), 1);

    // reset in the middle of capture
    @(negedge clk); trainStart = 1'b1;
    @(negedge clk); trainStart = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    checkIdle("R1");
    cmp("R1", "trainErr after mid reset", 32'(trainErr), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    runTrain(-1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule